// File: doc/BRIEF.md
# Peripheral-Muxed GPIO Port Controller

This block controls an 8-bit general-purpose I/O port whose pins can be handed over to three serial engines: one SPI and two UART-style interfaces. Software reaches the port through a small register bus with an address, a write strobe, write data and combinational read data. There are three registers. The output latch holds the values that GPIO drives. The direction register selects output (1) or input (0) for each pin. The pin-level register is read-only and shows the pad state after synchronization.

Each serial engine has an enable input. An enabled engine takes ownership of its own pin group ahead of GPIO. While it owns the group, it sets the pad's output enable and output value itself, and the block passes the pad levels back to that engine on its receive lines. When the engine is disabled, the group returns to GPIO control. The output latch goes on accepting writes while an engine owns the pins, so the latest value appears on the pads as soon as GPIO regains ownership.

Top module: `pmux_port`

## Requirements
- R1: While reset is asserted and right after it, the direction register is all zeros. With no serial engine enabled, every `pin_oe` bit is then 0.
- R2: Address 1 is the direction register. It can be written and read at any time, and a read returns the last value written.
- R3: Address 0 is the output latch. For each bit whose direction is 1, a read returns the last value written to the latch.
- R4: For each bit whose direction is 0, a read of address 0 returns the pin level. That level comes through a two-register synchronizer, so a read sees `pin_in` as it was sampled two clock edges earlier.
- R5: Address 2 returns the synchronized pin levels for all eight bits whatever the directions are. A write to address 2 changes no register, no pin output and no read value.
- R6: On a pin that GPIO owns, `pin_oe` equals that pin's direction bit and `pin_out` equals that pin's output latch bit.
- R7: When `spi_en` is 1, the SPI owns pins 7, 6, 5 and 4, which carry slave select, serial clock, MOSI and MISO in that order. With `spi_master`=1, pins 7 to 5 are driven from the matching `*_drv` inputs and pin 4 is an input. With `spi_master`=0, only pin 4 is driven, from `spi_miso_drv`, and pins 7 to 5 are inputs.
- R8: When `uart1_en` is 1, pin 3 is driven from `uart1_tx_drv` and pin 2 is an input.
- R9: When `uart0_en` is 1, pin 1 is driven from `uart0_tx_drv` and pin 0 is an input.
- R10: A pin that a serial engine owns but does not drive has `pin_oe`=0 and `pin_out`=0. Writes to the output latch made during ownership take effect on the pin once ownership returns to GPIO.
- R11: Each receive line (`*_rcv`) follows its pin's `pin_in` combinationally while its engine is enabled, and is 1 while the engine is disabled.
- R12: Address 3 is unused. It reads as zero and writes to it have no effect.
- R13: Reset does not change the output latch. A value written before reset reads back after reset once its direction bit is set to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| spi_en | input | 1 | SPI takes pins 7..4 |
| spi_master | input | 1 | SPI line directions: 1 master, 0 slave |
| spi_ss_drv | input | 1 | SPI slave-select value to drive |
| spi_sck_drv | input | 1 | SPI clock value to drive |
| spi_mosi_drv | input | 1 | SPI MOSI value to drive |
| spi_miso_drv | input | 1 | SPI MISO value to drive |
| spi_ss_rcv | output | 1 | Pin 7 level toward the SPI |
| spi_sck_rcv | output | 1 | Pin 6 level toward the SPI |
| spi_mosi_rcv | output | 1 | Pin 5 level toward the SPI |
| spi_miso_rcv | output | 1 | Pin 4 level toward the SPI |
| uart0_en | input | 1 | First UART takes pins 1..0 |
| uart0_tx_drv | input | 1 | First UART transmit value |
| uart0_rx_rcv | output | 1 | Pin 0 level toward the first UART |
| uart1_en | input | 1 | Second UART takes pins 3..2 |
| uart1_tx_drv | input | 1 | Second UART transmit value |
| uart1_rx_rcv | output | 1 | Pin 2 level toward the second UART |

## Verification
The directed phases use all-output, all-input and split direction masks with changing pad levels. These separate the latch path of an address-0 read from its synchronized-pin path, and they expose a synchronizer that is one stage short or one stage long. Each engine is enabled on its own and then together with the others, and the SPI is run in both master and slave mode. This shows that ownership stays inside the correct pin group and that the line directions follow the mode. Writes to the latch during ownership, writes to the read-only and unused addresses, and a reset between a latch write and its read-back cover the retention and write-ignore rules. A long phase with random bus traffic, pad levels and enables finally mixes all of these.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
   localparam int unsigned PORT_W = 8;

   // register addresses
   localparam int unsigned ADDR_LATCH = 0;
   localparam int unsigned ADDR_DIR   = 1;
   localparam int unsigned ADDR_LEVEL = 2;

   // pin positions decoded by the serial engines
   localparam int unsigned PIN_SS     = 7;
   localparam int unsigned PIN_SCK    = 6;
   localparam int unsigned PIN_MOSI   = 5;
   localparam int unsigned PIN_MISO   = 4;
   localparam int unsigned PIN_U1_TX  = 3;
   localparam int unsigned PIN_U1_RX  = 2;
   localparam int unsigned PIN_U0_TX  = 1;
   localparam int unsigned PIN_U0_RX  = 0;

   // value seen by a disabled engine on its receive lines
   localparam logic RCV_IDLE = 1'b1;

   typedef struct packed {
      logic [PORT_W-1:0] own;
      logic [PORT_W-1:0] oe;
      logic [PORT_W-1:0] val;
   } pin_claim_t;
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pmux_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pmux_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
   import pmux_pkg::*;
#(
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] level,
   output logic [PORT_W-1:0] rdata,
   output logic [PORT_W-1:0] latch_q,
   output logic [PORT_W-1:0] dir_q
);
   localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(ADDR_LATCH);
   localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(ADDR_DIR);
   localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(ADDR_LEVEL);

   logic              hit_latch, hit_dir, hit_level;
   logic [PORT_W-1:0] latch_view;

   assign hit_latch = (addr == A_LATCH);
   assign hit_dir   = (addr == A_DIR);
   assign hit_level = (addr == A_LEVEL);

   // output latch: no reset, keeps contents across reset
   always_ff @(posedge clk) begin
      if (rst_n && we && hit_latch) begin
         latch_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (we && hit_dir) begin
         dir_q <= wdata;
      end
   end

   // per-bit read-back choice for the latch address
   generate
      for (genvar b = 0; b < PORT_W; b++) begin : g_view
         assign latch_view[b] = dir_q[b] ? latch_q[b] : level[b];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (hit_latch) rdata = latch_view;
      if (hit_dir)   rdata = dir_q;
      if (hit_level) rdata = level;
   end
endmodule

// File: rtl/pmux_route.sv
module pmux_route
   import pmux_pkg::*;
(
   input  logic              spi_en,
   input  logic              spi_master,
   input  logic              spi_ss_drv,
   input  logic              spi_sck_drv,
   input  logic              spi_mosi_drv,
   input  logic              spi_miso_drv,
   input  logic              uart0_en,
   input  logic              uart0_tx_drv,
   input  logic              uart1_en,
   input  logic              uart1_tx_drv,
   input  logic [PORT_W-1:0] latch_q,
   input  logic [PORT_W-1:0] dir_q,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic              spi_ss_rcv,
   output logic              spi_sck_rcv,
   output logic              spi_mosi_rcv,
   output logic              spi_miso_rcv,
   output logic              uart0_rx_rcv,
   output logic              uart1_rx_rcv
);
   pin_claim_t claim;

   // engine claims; the groups are disjoint, any claim beats GPIO
   always_comb begin
      claim = '0;
      if (spi_en) begin
         claim.own[PIN_SS]   = 1'b1;
         claim.own[PIN_SCK]  = 1'b1;
         claim.own[PIN_MOSI] = 1'b1;
         claim.own[PIN_MISO] = 1'b1;
         claim.oe[PIN_SS]    = spi_master;
         claim.oe[PIN_SCK]   = spi_master;
         claim.oe[PIN_MOSI]  = spi_master;
         claim.oe[PIN_MISO]  = ~spi_master;
         claim.val[PIN_SS]   = spi_ss_drv;
         claim.val[PIN_SCK]  = spi_sck_drv;
         claim.val[PIN_MOSI] = spi_mosi_drv;
         claim.val[PIN_MISO] = spi_miso_drv;
      end
      if (uart1_en) begin
         claim.own[PIN_U1_TX] = 1'b1;
         claim.own[PIN_U1_RX] = 1'b1;
         claim.oe[PIN_U1_TX]  = 1'b1;
         claim.val[PIN_U1_TX] = uart1_tx_drv;
      end
      if (uart0_en) begin
         claim.own[PIN_U0_TX] = 1'b1;
         claim.own[PIN_U0_RX] = 1'b1;
         claim.oe[PIN_U0_TX]  = 1'b1;
         claim.val[PIN_U0_TX] = uart0_tx_drv;
      end
   end

   generate
      for (genvar p = 0; p < PORT_W; p++) begin : g_pad
         assign pin_oe[p]  = claim.own[p] ? claim.oe[p] : dir_q[p];
         assign pin_out[p] = claim.own[p] ? (claim.oe[p] & claim.val[p])
                                          : latch_q[p];
      end
   endgenerate

   assign spi_ss_rcv   = spi_en   ? pin_in[PIN_SS]    : RCV_IDLE;
   assign spi_sck_rcv  = spi_en   ? pin_in[PIN_SCK]   : RCV_IDLE;
   assign spi_mosi_rcv = spi_en   ? pin_in[PIN_MOSI]  : RCV_IDLE;
   assign spi_miso_rcv = spi_en   ? pin_in[PIN_MISO]  : RCV_IDLE;
   assign uart1_rx_rcv = uart1_en ? pin_in[PIN_U1_RX] : RCV_IDLE;
   assign uart0_rx_rcv = uart0_en ? pin_in[PIN_U0_RX] : RCV_IDLE;
endmodule

// File: rtl/pmux_port.sv
module pmux_port
   import pmux_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [PORT_W-1:0] reg_wdata,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   input  logic              spi_en,
   input  logic              spi_master,
   input  logic              spi_ss_drv,
   input  logic              spi_sck_drv,
   input  logic              spi_mosi_drv,
   input  logic              spi_miso_drv,
   output logic              spi_ss_rcv,
   output logic              spi_sck_rcv,
   output logic              spi_mosi_rcv,
   output logic              spi_miso_rcv,
   input  logic              uart0_en,
   input  logic              uart0_tx_drv,
   output logic              uart0_rx_rcv,
   input  logic              uart1_en,
   input  logic              uart1_tx_drv,
   output logic              uart1_rx_rcv
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pmux_port: ADDR_W must cover three registers");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pmux_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PORT_W-1:0] level;
   logic [PORT_W-1:0] latch_q;
   logic [PORT_W-1:0] dir_q;

   pmux_sync #(
      .W      (PORT_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (level)
   );

   pmux_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .we      (reg_we),
      .wdata   (reg_wdata),
      .level   (level),
      .rdata   (reg_rdata),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   pmux_route u_route (
      .spi_en       (spi_en),
      .spi_master   (spi_master),
      .spi_ss_drv   (spi_ss_drv),
      .spi_sck_drv  (spi_sck_drv),
      .spi_mosi_drv (spi_mosi_drv),
      .spi_miso_drv (spi_miso_drv),
      .uart0_en     (uart0_en),
      .uart0_tx_drv (uart0_tx_drv),
      .uart1_en     (uart1_en),
      .uart1_tx_drv (uart1_tx_drv),
      .latch_q      (latch_q),
      .dir_q        (dir_q),
      .pin_in       (pin_in),
      .pin_oe       (pin_oe),
      .pin_out      (pin_out),
      .spi_ss_rcv   (spi_ss_rcv),
      .spi_sck_rcv  (spi_sck_rcv),
      .spi_mosi_rcv (spi_mosi_rcv),
      .spi_miso_rcv (spi_miso_rcv),
      .uart0_rx_rcv (uart0_rx_rcv),
      .uart1_rx_rcv (uart1_rx_rcv)
   );
endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk #(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        reg_rdata,
   input logic [7:0]        pin_in,
   input logic [7:0]        pin_oe,
   input logic [7:0]        pin_out,
   input logic              spi_en,
   input logic              spi_master,
   input logic              spi_ss_drv,
   input logic              spi_sck_drv,
   input logic              spi_mosi_drv,
   input logic              spi_miso_drv,
   input logic              uart0_en,
   input logic              uart0_tx_drv,
   input logic              uart0_rx_rcv,
   input logic              uart1_en,
   input logic              uart1_tx_drv,
   input logic              uart1_rx_rcv
);
   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1: first sampled cycle after reset, nothing driven from GPIO
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !spi_en && !uart0_en && !uart1_en) |-> (pin_oe == 8'h00));

   // R2: a direction write reads back on the following cycle
   assert_dir_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(1)) |=>
         (reg_addr != ADDR_W'(1) || reg_rdata == $past(reg_wdata)));

   // R5: level register shows pin_in from two edges back
   generate
      if (SYNC_STAGES == 2) begin : g_lvl
         assert_level_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd2 && reg_addr == ADDR_W'(2)) |-> (reg_rdata == $past(pin_in, 2)));
      end
   endgenerate

   // R7: SPI master and slave pin roles
   assert_spi_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && spi_master) |->
         (pin_oe[7:4] == 4'b1110 &&
          pin_out[7:5] == {spi_ss_drv, spi_sck_drv, spi_mosi_drv}));
   assert_spi_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && !spi_master) |->
         (pin_oe[7:4] == 4'b0001 && pin_out[4] == spi_miso_drv));

   // R8, R9: UART transmit driven, receive pin undriven (R10)
   assert_uart1_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uart1_en |-> (pin_oe[3:2] == 2'b10 && pin_out[3:2] == {uart1_tx_drv, 1'b0}));
   assert_uart0_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uart0_en |-> (pin_oe[1:0] == 2'b10 && pin_out[1:0] == {uart0_tx_drv, 1'b0}));

   // R11: disabled receivers idle high
   assert_rx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((!uart0_en -> uart0_rx_rcv) && (!uart1_en -> uart1_rx_rcv)));

   // R12: unused address reads zero
   assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(3)) |-> (reg_rdata == 8'h00));
endmodule

bind pmux_port pmux_port_chk #(
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_we       (reg_we),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .pin_in       (pin_in),
   .pin_oe       (pin_oe),
   .pin_out      (pin_out),
   .spi_en       (spi_en),
   .spi_master   (spi_master),
   .spi_ss_drv   (spi_ss_drv),
   .spi_sck_drv  (spi_sck_drv),
   .spi_mosi_drv (spi_mosi_drv),
   .spi_miso_drv (spi_miso_drv),
   .uart0_en     (uart0_en),
   .uart0_tx_drv (uart0_tx_drv),
   .uart0_rx_rcv (uart0_rx_rcv),
   .uart1_en     (uart1_en),
   .uart1_tx_drv (uart1_tx_drv),
   .uart1_rx_rcv (uart1_rx_rcv)
);

// File: tb/pmux_port_tb.sv
module pmux_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out;
   logic spi_en = 0, spi_master = 0;
   logic spi_ss_drv = 0, spi_sck_drv = 0, spi_mosi_drv = 0, spi_miso_drv = 0;
   logic spi_ss_rcv, spi_sck_rcv, spi_mosi_rcv, spi_miso_rcv;
   logic uart0_en = 0, uart0_tx_drv = 0, uart0_rx_rcv;
   logic uart1_en = 0, uart1_tx_drv = 0, uart1_rx_rcv;

   int n_chk = 0;
   int n_bad = 0;

   // reference state
   bit [7:0] m_dir = '0, m_latch = '0, m_known = '0;
   bit [7:0] pin_hist[$];

   always #5 clk = ~clk;

   pmux_port u_dut (.*);

   task automatic check(string req, string what, logic [7:0] act, bit [7:0] exp, bit [7:0] mask);
      n_chk++;
      if (((act ^ exp) & mask) != 0 || ($isunknown(act & mask))) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (mask %h)", req, what, act, exp, mask);
      end
   endtask

   function automatic bit [7:0] level_now();
      return (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 8'h00;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m_dir = '0;
         pin_hist.delete();
      end else begin
         if (reg_we && reg_addr == 2'd0) begin
            m_latch = reg_wdata;
            m_known = 8'hFF;
         end
         if (reg_we && reg_addr == 2'd1) m_dir = reg_wdata;
         pin_hist.push_back(pin_in);
         if (pin_hist.size() > 4) void'(pin_hist.pop_front());
      end
   endtask

   task automatic compare();
      bit [7:0] e_oe, e_out, own, mask_out, e_rd, mask_rd, lvl;
      bit [7:0] e_rcv;
      string    rq;
      lvl = level_now();
      own = '0; e_oe = m_dir; e_out = m_latch;
      if (spi_en) begin
         own[7:4] = 4'hF;
         e_oe[7:4] = spi_master ? 4'b1110 : 4'b0001;
         e_out[7:4] = spi_master ? {spi_ss_drv, spi_sck_drv, spi_mosi_drv, 1'b0}
                                 : {3'b000, spi_miso_drv};
      end
      if (uart1_en) begin
         own[3:2] = 2'b11; e_oe[3:2] = 2'b10; e_out[3:2] = {uart1_tx_drv, 1'b0};
      end
      if (uart0_en) begin
         own[1:0] = 2'b11; e_oe[1:0] = 2'b10; e_out[1:0] = {uart0_tx_drv, 1'b0};
      end
      mask_out = own | (~own & m_dir & m_known);
      rq = !rst_n ? "R1" : (own != 0 ? "R7 R8 R9 R10" : "R6 R10");
      check(rq, "pin_oe", pin_oe, e_oe, 8'hFF);
      check(rq, "pin_out", pin_out, e_out, mask_out);
      if (rst_n) begin
         mask_rd = 8'hFF;
         case (reg_addr)
            2'd0: begin
               for (int b = 0; b < 8; b++) e_rd[b] = m_dir[b] ? m_latch[b] : lvl[b];
               mask_rd = ~m_dir | m_known;
               rq = "R3 R4 R13";
            end
            2'd1: begin e_rd = m_dir; rq = "R2"; end
            2'd2: begin e_rd = lvl; rq = "R5"; end
            default: begin e_rd = 8'h00; rq = "R12"; end
         endcase
         check(rq, "reg_rdata", reg_rdata, e_rd, mask_rd);
      end
      e_rcv = {2'b00,
               spi_en ? pin_in[7] : 1'b1, spi_en ? pin_in[6] : 1'b1,
               spi_en ? pin_in[5] : 1'b1, spi_en ? pin_in[4] : 1'b1,
               uart1_en ? pin_in[2] : 1'b1, uart0_en ? pin_in[0] : 1'b1};
      check("R11", "rcv", {2'b00, spi_ss_rcv, spi_sck_rcv, spi_mosi_rcv, spi_miso_rcv,
                            uart1_rx_rcv, uart0_rx_rcv}, e_rcv, 8'h3F);
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      #2;
      compare();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input int n);
      reg_addr = a;
      for (int i = 0; i < n; i++) begin
         pin_in = 8'($urandom);
         tick();
      end
   endtask

   task automatic rnd_drv();
      {spi_ss_drv, spi_sck_drv, spi_mosi_drv, spi_miso_drv, uart0_tx_drv, uart1_tx_drv} = 6'($urandom);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      rd(2'd0, 3);
      #3 rst_n = 1'b1;
      tick();
      // R2, R3, R6: all outputs
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'hA5);
      rd(2'd0, 4);
      rd(2'd1, 2);
      // R4: all inputs, then split mask
      wr(2'd1, 8'h00);
      rd(2'd0, 8);
      wr(2'd1, 8'h0F);
      rd(2'd0, 8);
      rd(2'd2, 8);
      // R5: write to the level register is ignored
      wr(2'd2, 8'h5A);
      rd(2'd0, 2); rd(2'd1, 1); rd(2'd2, 3);
      // R12: unused address
      wr(2'd3, 8'hFF);
      rd(2'd3, 2); rd(2'd1, 1); rd(2'd0, 2);
      // R7: SPI master then slave, R10 writes while owned
      wr(2'd1, 8'hFF);
      spi_en = 1; spi_master = 1;
      for (int i = 0; i < 6; i++) begin rnd_drv(); rd(2'd2, 1); end
      wr(2'd0, 8'h3C);
      spi_master = 0;
      for (int i = 0; i < 6; i++) begin rnd_drv(); rd(2'd0, 1); end
      spi_en = 0;
      rd(2'd0, 3);
      // R8, R9: UARTs alone and together
      uart1_en = 1;
      for (int i = 0; i < 5; i++) begin rnd_drv(); rd(2'd0, 1); end
      uart1_en = 0; uart0_en = 1;
      for (int i = 0; i < 5; i++) begin rnd_drv(); rd(2'd1, 1); end
      wr(2'd0, 8'hC3);
      uart1_en = 1; spi_en = 1; spi_master = 1;
      for (int i = 0; i < 6; i++) begin rnd_drv(); rd(2'd0, 1); end
      spi_en = 0; uart0_en = 0; uart1_en = 0;
      rd(2'd0, 3);
      // R13: latch survives reset
      wr(2'd0, 8'h96);
      #3 rst_n = 1'b0;
      rd(2'd0, 3);
      #3 rst_n = 1'b1;
      tick();
      wr(2'd1, 8'hFF);
      rd(2'd0, 3);
      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         reg_addr = 2'($urandom);
         reg_we = ($urandom % 3) == 0;
         reg_wdata = 8'($urandom);
         pin_in = 8'($urandom);
         {spi_en, spi_master, uart0_en, uart1_en} = 4'($urandom);
         rnd_drv();
         tick();
      end
      reg_we = 1'b0;
      summary();
      $finish;
   end
endmodule